// File: doc/BRIEF.md
# Endian-Aware Vector Load/Store Formatter

This block formats data moving between a memory data port and a bank of 32-bit vector register words. A transfer moves a block of 1, 2, 3, 4, 6, 8, 12 or 16 bytes made of elements 1, 2, 4 or 8 bytes wide. The block forms the effective address from a base and an immediate. It converts the byte order of every element on its own, so 16-bit, 32-bit and 64-bit lanes come out right in either endian mode. It clears every byte that lies past the end of the transfer, including the upper bytes of a final partial register word.

On a load the memory bytes are byte-order converted first and then placed into register words, lowest-addressed bytes in word 0. On a store the register words are gathered into a flat byte block first and then converted. The formatting path is combinational. Results, the effective address and the number of register words touched are captured into output registers one cycle after a request. A valid strobe goes with each result. A request whose size and element width do not fit together raises an error strobe instead and leaves every result register untouched.

Top module: `vec_mem_formatter`

## Requirements
- R1: While reset is held and right after it, every output is zero.
- R2: One cycle after a legal request `vld_o` is 1 and `err_o` is 0. One cycle after an illegal request `err_o` is 1 and `vld_o` is 0. After a cycle with no request both are 0.
- R3: On a legal request `ea_o` becomes `base_i + imm_i` modulo 2^32, with no scaling of the immediate.
- R4: A request is legal only if all three of these hold. The size is one of 1, 2, 3, 4, 6, 8, 12, 16. The size is a whole multiple of the element width. The element count (size / width) is at most 4, or the size is 8 or 16.
- R5: After an illegal request, `ea_o`, `word_cnt_o`, `reg_data_o` and `mem_wdata_o` keep their previous values.
- R6: On a legal request `word_cnt_o` becomes the size divided by four, rounded up.
- R7: With `big_end_i`=0, a load copies memory byte i (bits 8i+7:8i of `mem_rdata_i`) to byte i of the flat register image, so register word k (bits 32k+31:32k) holds bytes 4k to 4k+3.
- R8: With `big_end_i`=1, each element is byte-reversed within itself before placement. The element width is selected by `elem_sz_i` (0 = 1 byte, 1 = 2, 2 = 4, 3 = 8). Byte j of an element starting at byte e becomes byte e+w-1-j.
- R9: Every result byte at an index equal to or above the size is zero. This clears the upper bits of a final partial word and all untouched words.
- R10: A store takes the register words as a flat byte image (word k giving bytes 4k to 4k+3), applies the same per-element conversion and tail clearing, and presents it on `mem_wdata_o`.
- R11: A legal load updates only `reg_data_o`, and a legal store updates only `mem_wdata_o`. The other data output holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe, one cycle per transfer |
| is_store_i | input | 1 | 1 = store, 0 = load |
| big_end_i | input | 1 | 1 = big-endian element order |
| elem_sz_i | input | 2 | Element width code: 0/1/2/3 = 1/2/4/8 bytes |
| xfer_sz_i | input | 5 | Transfer size in bytes |
| base_i | input | 32 | Base address |
| imm_i | input | 32 | Immediate offset |
| mem_rdata_i | input | 128 | Load data, byte i at bits 8i+7:8i |
| reg_wdata_i | input | 128 | Store source, register word k at bits 32k+31:32k |
| ea_o | output | 32 | Effective address |
| reg_data_o | output | 128 | Formatted load result as register words |
| mem_wdata_o | output | 128 | Formatted store bytes |
| word_cnt_o | output | 3 | Register words touched |
| vld_o | output | 1 | Result valid strobe |
| err_o | output | 1 | Illegal size/width strobe |

## Verification
The assertions assume that `xfer_sz_i`, `base_i`, `imm_i` and `is_store_i` carry meaning only in the cycle where `req_i` is high. They relate each strobe to the inputs seen one edge earlier. They also assume that nothing other than a legal request changes the result registers. The stimulus holds to this by driving every input on the falling edge and by pulsing the request for exactly one cycle. Random sizes are drawn from the whole 5-bit range together with every element width, so illegal combinations reach the error path between legal ones.

// File: rtl/vfmt_pkg.sv
package vfmt_pkg;

   typedef enum logic [1:0] {
      EW_1B = 2'd0,
      EW_2B = 2'd1,
      EW_4B = 2'd2,
      EW_8B = 2'd3
   } elem_w_e;

   // transfer sizes the formatter accepts
   function automatic logic size_in_set(input logic [7:0] sz);
      case (sz)
         8'd1, 8'd2, 8'd3, 8'd4, 8'd6, 8'd8, 8'd12, 8'd16: size_in_set = 1'b1;
         default:                                          size_in_set = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/vfmt_legal.sv
module vfmt_legal #(
   parameter int SZ_W = 5
) (
   input  logic [SZ_W-1:0] size_i,
   input  logic [1:0]      esz_i,
   output logic            ok_o
);
   import vfmt_pkg::*;

   elem_w_e         ew;
   logic [SZ_W-1:0] low_mask;
   logic [SZ_W-1:0] n_elem;
   logic            whole;

   always_comb begin
      ew       = elem_w_e'(esz_i);
      low_mask = (SZ_W'(1) << ew) - SZ_W'(1);
      whole    = (size_i & low_mask) == '0;
      n_elem   = size_i >> ew;
      ok_o     = size_in_set(8'(size_i)) && whole &&
                 ((n_elem <= SZ_W'(4)) || (size_i == SZ_W'(8)) || (size_i == SZ_W'(16)));
   end
endmodule

// File: rtl/vfmt_elem_swap.sv
module vfmt_elem_swap #(
   parameter int LANE_BYTES = 16,
   localparam int DATA_W    = LANE_BYTES * 8,
   localparam int N_WIDTHS  = 4
) (
   input  logic [DATA_W-1:0] din,
   input  logic [1:0]        esz_i,
   input  logic              big_end_i,
   output logic [DATA_W-1:0] dout
);
   logic [DATA_W-1:0] variant [N_WIDTHS];

   for (genvar gw = 0; gw < N_WIDTHS; gw++) begin : g_width
      localparam int EB = 1 << gw;
      localparam int NE = LANE_BYTES / EB;
      logic [DATA_W-1:0] rev;
      for (genvar e = 0; e < NE; e++) begin : g_elem
         for (genvar b = 0; b < EB; b++) begin : g_byte
            assign rev[(e*EB + b)*8 +: 8] = din[(e*EB + EB - 1 - b)*8 +: 8];
         end
      end
      assign variant[gw] = rev;
   end

   assign dout = big_end_i ? variant[esz_i] : din;
endmodule

// File: rtl/vfmt_tail_mask.sv
module vfmt_tail_mask #(
   parameter int LANE_BYTES = 16,
   parameter int WORD_BYTES = 4,
   localparam int DATA_W    = LANE_BYTES * 8,
   localparam int NWORDS    = LANE_BYTES / WORD_BYTES,
   localparam int SZ_W      = $clog2(LANE_BYTES + 1),
   localparam int CNT_W     = $clog2(NWORDS + 1)
) (
   input  logic [DATA_W-1:0] din,
   input  logic [SZ_W-1:0]   size_i,
   output logic [DATA_W-1:0] dout,
   output logic [CNT_W-1:0]  words_o
);
   logic [SZ_W:0] rounded;

   for (genvar i = 0; i < LANE_BYTES; i++) begin : g_keep
      assign dout[i*8 +: 8] = (size_i > SZ_W'(i)) ? din[i*8 +: 8] : 8'h00;
   end

   assign rounded = {1'b0, size_i} + (SZ_W + 1)'(WORD_BYTES - 1);
   assign words_o = CNT_W'(rounded / (SZ_W + 1)'(WORD_BYTES));
endmodule

// File: rtl/vec_mem_formatter.sv
module vec_mem_formatter #(
   parameter int LANE_BYTES = 16,
   parameter int WORD_BYTES = 4,
   parameter int ADDR_W     = 32,
   localparam int DATA_W    = LANE_BYTES * 8,
   localparam int NWORDS    = LANE_BYTES / WORD_BYTES,
   localparam int SZ_W      = $clog2(LANE_BYTES + 1),
   localparam int CNT_W     = $clog2(NWORDS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              is_store_i,
   input  logic              big_end_i,
   input  logic [1:0]        elem_sz_i,
   input  logic [SZ_W-1:0]   xfer_sz_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [ADDR_W-1:0] imm_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [ADDR_W-1:0] ea_o,
   output logic [DATA_W-1:0] reg_data_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   output logic [CNT_W-1:0]  word_cnt_o,
   output logic              vld_o,
   output logic              err_o
);
   // elaboration-time parameter checks
   if (LANE_BYTES < 16 || (LANE_BYTES % 8) != 0) begin : g_bad_lane
      $error("LANE_BYTES must be a multiple of 8 and at least 16");
   end
   if (WORD_BYTES < 1 || (LANE_BYTES % WORD_BYTES) != 0) begin : g_bad_word
      $error("WORD_BYTES must divide LANE_BYTES");
   end

   logic [DATA_W-1:0] src, swapped, formatted;
   logic [CNT_W-1:0]  words;
   logic              legal;
   logic              take;

   assign src  = is_store_i ? reg_wdata_i : mem_rdata_i;
   assign take = req_i && legal;

   vfmt_legal #(.SZ_W(SZ_W)) u_legal (
      .size_i (xfer_sz_i),
      .esz_i  (elem_sz_i),
      .ok_o   (legal)
   );

   vfmt_elem_swap #(.LANE_BYTES(LANE_BYTES)) u_swap (
      .din       (src),
      .esz_i     (elem_sz_i),
      .big_end_i (big_end_i),
      .dout      (swapped)
   );

   vfmt_tail_mask #(.LANE_BYTES(LANE_BYTES), .WORD_BYTES(WORD_BYTES)) u_mask (
      .din     (swapped),
      .size_i  (xfer_sz_i),
      .dout    (formatted),
      .words_o (words)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ea_o        <= '0;
         reg_data_o  <= '0;
         mem_wdata_o <= '0;
         word_cnt_o  <= '0;
         vld_o       <= 1'b0;
         err_o       <= 1'b0;
      end else begin
         vld_o <= take;
         err_o <= req_i && !legal;
         if (take) begin
            ea_o       <= base_i + imm_i;
            word_cnt_o <= words;
            if (is_store_i) mem_wdata_o <= formatted;
            else            reg_data_o  <= formatted;
         end
      end
   end
endmodule

// File: rtl/vfmt_checker.sv
module vfmt_checker #(
   parameter int LANE_BYTES = 16,
   parameter int WORD_BYTES = 4,
   parameter int ADDR_W     = 32,
   localparam int DATA_W    = LANE_BYTES * 8,
   localparam int NWORDS    = LANE_BYTES / WORD_BYTES,
   localparam int SZ_W      = $clog2(LANE_BYTES + 1),
   localparam int CNT_W     = $clog2(NWORDS + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_i,
   input logic              is_store_i,
   input logic [SZ_W-1:0]   xfer_sz_i,
   input logic [ADDR_W-1:0] base_i,
   input logic [ADDR_W-1:0] imm_i,
   input logic [ADDR_W-1:0] ea_o,
   input logic [DATA_W-1:0] reg_data_o,
   input logic [DATA_W-1:0] mem_wdata_o,
   input logic [CNT_W-1:0]  word_cnt_o,
   input logic              vld_o,
   input logic              err_o
);
   p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(vld_o && err_o));

   p_vld_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_o || err_o) |-> $past(req_i));

   p_ea_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |-> ea_o == $past(base_i) + $past(imm_i));

   p_err_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> ($stable(ea_o) && $stable(word_cnt_o) &&
                 $stable(reg_data_o) && $stable(mem_wdata_o)));

   p_word_cnt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |-> int'(word_cnt_o) ==
                (int'($past(xfer_sz_i)) + WORD_BYTES - 1) / WORD_BYTES);

   p_load_tail_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_o && !$past(is_store_i)) |->
         (reg_data_o >> (8 * int'($past(xfer_sz_i)))) == '0);

   p_store_tail_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_o && $past(is_store_i)) |->
         (mem_wdata_o >> (8 * int'($past(xfer_sz_i)))) == '0);

   p_dir_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |-> ($past(is_store_i) ? $stable(reg_data_o) : $stable(mem_wdata_o)));
endmodule

bind vec_mem_formatter vfmt_checker #(
   .LANE_BYTES (LANE_BYTES),
   .WORD_BYTES (WORD_BYTES),
   .ADDR_W     (ADDR_W)
) u_vfmt_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_i       (req_i),
   .is_store_i  (is_store_i),
   .xfer_sz_i   (xfer_sz_i),
   .base_i      (base_i),
   .imm_i       (imm_i),
   .ea_o        (ea_o),
   .reg_data_o  (reg_data_o),
   .mem_wdata_o (mem_wdata_o),
   .word_cnt_o  (word_cnt_o),
   .vld_o       (vld_o),
   .err_o       (err_o)
);

// File: tb/tb_vec_mem_formatter.sv
`timescale 1ns/1ps
module tb_vec_mem_formatter;
   logic         clk = 1'b0;
   logic         rst_n;
   logic         req_i, is_store_i, big_end_i;
   logic [1:0]   elem_sz_i;
   logic [4:0]   xfer_sz_i;
   logic [31:0]  base_i, imm_i;
   logic [127:0] mem_rdata_i, reg_wdata_i;
   logic [31:0]  ea_o;
   logic [127:0] reg_data_o, mem_wdata_o;
   logic [2:0]   word_cnt_o;
   logic         vld_o, err_o;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   // shadow of the result registers
   logic [31:0]  x_ea;
   logic [127:0] x_reg, x_mem;
   logic [2:0]   x_cnt;

   always #5 clk = ~clk;

   vec_mem_formatter dut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .is_store_i(is_store_i),
      .big_end_i(big_end_i), .elem_sz_i(elem_sz_i), .xfer_sz_i(xfer_sz_i),
      .base_i(base_i), .imm_i(imm_i), .mem_rdata_i(mem_rdata_i),
      .reg_wdata_i(reg_wdata_i), .ea_o(ea_o), .reg_data_o(reg_data_o),
      .mem_wdata_o(mem_wdata_o), .word_cnt_o(word_cnt_o), .vld_o(vld_o),
      .err_o(err_o)
   );

   function automatic bit legal_ref(input int esz, input int sz);
      int eb = 1 << esz;
      bit in_set = (sz == 1 || sz == 2 || sz == 3 || sz == 4 ||
                    sz == 6 || sz == 8 || sz == 12 || sz == 16);
      return in_set && (sz % eb == 0) && ((sz / eb) <= 4 || sz == 8 || sz == 16);
   endfunction

   function automatic logic [127:0] fmt_ref(input logic [127:0] d, input int esz,
                                            input int sz, input bit big);
      logic [127:0] r = '0;
      int eb = 1 << esz;
      for (int i = 0; i < 16; i++) begin
         int s = big ? (i / eb) * eb + (eb - 1 - i % eb) : i;
         if (i < sz) r[i*8 +: 8] = d[s*8 +: 8];
      end
      return r;
   endfunction

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_op(input bit st, input int esz, input int sz, input bit big,
                        input logic [31:0] b, input logic [31:0] im,
                        input logic [127:0] md, input logic [127:0] rd);
      bit ok = legal_ref(esz, sz);
      @(negedge clk);
      req_i = 1'b1; is_store_i = st; big_end_i = big;
      elem_sz_i = 2'(esz); xfer_sz_i = 5'(sz);
      base_i = b; imm_i = im; mem_rdata_i = md; reg_wdata_i = rd;
      @(negedge clk);
      req_i = 1'b0;
      if (ok) begin
         x_ea  = b + im;
         x_cnt = 3'((sz + 3) / 4);
         if (st) x_mem = fmt_ref(rd, esz, sz, big);
         else    x_reg = fmt_ref(md, esz, sz, big);
         chk("R2 vld after legal", 128'(vld_o), 128'(1));
         chk("R2 no err on legal", 128'(err_o), 128'(0));
         chk("R3 effective address", 128'(ea_o), 128'(x_ea));
         chk("R6 word count", 128'(word_cnt_o), 128'(x_cnt));
         if (st) begin
            chk("R10/R8/R9 store bytes", mem_wdata_o, x_mem);
            chk("R11 load result held on store", reg_data_o, x_reg);
         end else begin
            chk(big ? "R8/R9 load big-endian" : "R7/R9 load little-endian", reg_data_o, x_reg);
            chk("R11 store result held on load", mem_wdata_o, x_mem);
         end
      end else begin
         chk("R4 err on illegal", 128'(err_o), 128'(1));
         chk("R4 no vld on illegal", 128'(vld_o), 128'(0));
         chk("R5 ea held", 128'(ea_o), 128'(x_ea));
         chk("R5 word count held", 128'(word_cnt_o), 128'(x_cnt));
         chk("R5 load data held", reg_data_o, x_reg);
         chk("R5 store data held", mem_wdata_o, x_mem);
      end
   endtask

   function automatic logic [127:0] rnd128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin : main
      logic [127:0] pat;
      void'($urandom(32'd4242));
      for (int i = 0; i < 16; i++) pat[i*8 +: 8] = 8'(8'h10 + i);
      rst_n = 1'b0; req_i = 1'b0; is_store_i = 1'b0; big_end_i = 1'b0;
      elem_sz_i = '0; xfer_sz_i = '0; base_i = '0; imm_i = '0;
      mem_rdata_i = '0; reg_wdata_i = '0;
      x_ea = '0; x_reg = '0; x_mem = '0; x_cnt = '0;
      repeat (3) @(negedge clk);
      chk("R1 reset ea", 128'(ea_o), 128'(0));
      chk("R1 reset load data", reg_data_o, '0);
      chk("R1 reset store data", mem_wdata_o, '0);
      chk("R1 reset strobes", 128'({vld_o, err_o, word_cnt_o}), 128'(0));
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset idle", 128'({vld_o, err_o}), 128'(0));

      // directed corner cases
      do_op(0, 0, 16, 0, 32'h1000, 32'h10, pat, '0);        // R7 plain copy
      do_op(0, 3, 16, 1, 32'h2000, 32'h4, pat, '0);         // R8 64-bit lanes
      do_op(0, 1, 6, 1, 32'h3000, 32'h0, pat, '0);          // R9 partial word
      do_op(0, 0, 3, 0, 32'h40, 32'h3, pat, '0);            // R9 three bytes
      do_op(0, 2, 12, 1, 32'h80, 32'h8, pat, '0);           // R8 32-bit lanes
      do_op(1, 2, 4, 1, 32'h100, 32'h0, '0, pat);           // R10 store
      do_op(1, 0, 1, 0, 32'h104, 32'h1, '0, pat);           // R10 single byte
      do_op(0, 0, 5, 0, 32'h5, 32'h5, pat, '0);             // R4 size not in set
      do_op(0, 0, 12, 0, 32'h6, 32'h6, pat, '0);            // R4 too many elements
      do_op(1, 2, 6, 0, 32'h7, 32'h7, '0, pat);             // R4 not whole elements
      do_op(0, 0, 0, 0, 32'h8, 32'h8, pat, '0);             // R4 zero size
      do_op(0, 1, 12, 0, 32'h9, 32'h9, pat, '0);            // R4 six halfwords
      do_op(0, 0, 8, 1, 32'hFFFF_FFF0, 32'h20, pat, '0);    // R3 wrap
      @(negedge clk);
      chk("R2 idle cycle strobes", 128'({vld_o, err_o}), 128'(0));

      // constrained random mix
      for (int n = 0; n < 600; n++) begin
         int sz  = ($urandom % 4 == 0) ? int'($urandom % 32) : 0;
         int esz = int'($urandom % 4);
         if (sz == 0) begin
            case ($urandom % 8)
               0: sz = 1;  1: sz = 2;  2: sz = 3;  3: sz = 4;
               4: sz = 6;  5: sz = 8;  6: sz = 12; default: sz = 16;
            endcase
         end
         do_op(bit'($urandom % 2), esz, sz, bit'($urandom % 2),
               $urandom, $urandom, rnd128(), rnd128());
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule